// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner and Word Deframer

This block sits behind a clock-recovery stage and takes the recovered serial line one bit at a time, with a strobe that marks each valid bit. The transmitter sends ordinary payload traffic and no training pattern. The block finds the 28-bit frame boundary by itself. It uses only the two fixed embedded clock bits and a parity bit carried in each frame. Once it trusts an alignment it raises `locked`. From then on it delivers one 24-bit word per frame, with a one-cycle strobe.

Each frame carries a balance flag. When that flag is set, the transmitter has inverted the payload, and the block inverts it back before output. If the embedded clock bits are wrong in even a single frame, the block drops `locked` and starts searching again without outside help. A receive-enable input marks the parallel word and its strobe as driven or not driven, and it leaves the lock state untouched.

Top module: `dfr_deframer`

## Requirements
- R1: While reset is applied and right after it, `locked`, `word_stb` and `par_word` are all 0.
- R2: A frame is 28 bits, received first to last in this order: start clock bit (must be 1), balance flag, parity bit, payload bits p0 to p23, end clock bit (must be 0). Output bit i of `par_word` carries payload bit pi.
- R3: Lock is declared after 4 consecutive aligned frames that each pass both the clock-bit check and the parity check. `locked` rises in the same cycle as the first `word_stb`, and that strobe carries the 4th frame's word.
- R4: During the search, a frame that fails the clock-bit check moves the candidate frame start by one bit and restarts the count of good frames. No special pattern is needed to find alignment.
- R5: The parity bit makes the total number of ones in the balance flag, the parity bit and the 24 payload bits even. A parity failure during the search also moves the candidate start and restarts the count.
- R6: While locked, a frame that fails only the parity check keeps lock, and its word is still delivered.
- R7: While locked, a single frame whose start bit reads 0 or whose end bit reads 1 drops `locked`. The drop happens in the cycle after that frame's last bit, and that frame produces no strobe.
- R8: When the balance flag of a frame is 1, the 24 received payload bits are inverted before output. When it is 0, they pass through unchanged.
- R9: While `locked` is low, `par_word` is 0 and `word_stb` is low.
- R10: While `rx_en` is low, `par_oe` is low, `par_word` is 0 and `word_stb` is low. The lock state is unaffected and keeps following the line.
- R11: After a loss of lock, the block reacquires lock by itself on continuing traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock from the recovery stage |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_bit | input | 1 | Recovered serial bit |
| ser_vld | input | 1 | Marks `ser_bit` as a valid bit in this cycle |
| rx_en | input | 1 | Receive enable for the parallel outputs |
| par_word | output | 24 | Decoded payload word |
| word_stb | output | 1 | One-cycle pulse with each delivered word |
| par_oe | output | 1 | High when the parallel outputs are driven |
| locked | output | 1 | Frame alignment established; the word is valid |

## Verification
Two events can land on the same clock edge. The first is acceptance of an alignment, which coincides with delivery of the first word. This is provoked by four clean aligned frames, and the bench checks that `locked` and `word_stb` are both high at the sample after the fourth frame, with that frame's data on the output. The second is a clock-bit violation while locked, which collides with word delivery. A frame with its end bit forced to 1 is sent, and the bench checks that lock falls, no strobe appears and the word returns to zero at that same sample. A parity-only error is sent both before and after lock to show that it restarts the search in one state and is ignored in the other.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam int PAY_W      = 24;
  localparam int OVH_BITS   = 4;
  localparam int ACQ_FRAMES = 4;
endpackage

// File: rtl/dfr_window.sv
module dfr_window #(
  parameter int FW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [FW-1:0] win_nxt
);
  logic [FW-1:0] win_q;
  logic [FW-1:0] win_d;

  always_comb begin
    win_d   = {win_q[FW-2:0], bit_in};
    win_nxt = win_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_q <= '0;
    else if (shift_en) win_q <= win_d;
  end
endmodule

// File: rtl/dfr_check.sv
module dfr_check #(
  parameter int PW = 24
) (
  input  logic [PW+3:0] win,
  output logic          clk_ok,
  output logic          par_ok,
  output logic [PW-1:0] word
);
  localparam int FW = PW + 4;

  logic dcb;

  // Last-received bit sits at index 0; the start clock bit at FW-1.
  assign dcb    = win[FW-2];
  assign clk_ok = win[FW-1] & ~win[0];
  assign par_ok = ~(^win[FW-2:1]);

  for (genvar i = 0; i < PW; i++) begin : g_pay
    assign word[i] = win[FW-4-i] ^ dcb;
  end
endmodule

// File: rtl/dfr_lock.sv
module dfr_lock #(
  parameter int FW  = 28,
  parameter int ACQ = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic clk_ok,
  input  logic par_ok,
  output logic deliver,
  output logic lock_q,
  output logic lock_n
);
  localparam int CW = $clog2(FW);
  localparam int SW = $clog2(ACQ + 1);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);
  localparam logic [SW-1:0] STREAK_DONE = SW'(ACQ - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [SW-1:0] streak_q, streak_n;
  logic          eval;

  assign eval = bit_vld && (cnt_q == LAST);

  always_comb begin
    cnt_n    = cnt_q;
    streak_n = streak_q;
    lock_n   = lock_q;
    deliver  = 1'b0;
    if (eval) begin
      if (lock_q) begin
        if (!clk_ok) begin
          lock_n   = 1'b0;
          streak_n = '0;
          cnt_n    = LAST;
        end else begin
          deliver = 1'b1;
          cnt_n   = '0;
        end
      end else if (clk_ok && par_ok) begin
        cnt_n = '0;
        if (streak_q == STREAK_DONE) begin
          lock_n   = 1'b1;
          deliver  = 1'b1;
          streak_n = '0;
        end else begin
          streak_n = streak_q + 1'b1;
        end
      end else begin
        // Slip: evaluate again one bit later.
        cnt_n    = LAST;
        streak_n = '0;
      end
    end else if (bit_vld) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      streak_q <= '0;
      lock_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      streak_q <= streak_n;
      lock_q   <= lock_n;
    end
  end

  assert_drop_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && eval && !clk_ok) |=> !lock_q);

  assert_slip_on_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && eval && !(clk_ok && par_ok)) |=> (cnt_q == LAST && !lock_q));

  assert_keep_on_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && eval && clk_ok && !par_ok) |=> lock_q);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/dfr_deframer.sv
module dfr_deframer
  import dfr_pkg::*;
#(
  parameter int PW  = PAY_W,
  parameter int ACQ = ACQ_FRAMES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_bit,
  input  logic          ser_vld,
  input  logic          rx_en,
  output logic [PW-1:0] par_word,
  output logic          word_stb,
  output logic          par_oe,
  output logic          locked
);
  localparam int FW = PW + OVH_BITS;

  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic [FW-1:0] win_nxt;
  logic          clk_ok, par_ok, deliver, lock_q, lock_n;
  logic [PW-1:0] dec_word;
  logic [PW-1:0] word_q, word_n;
  logic          stb_q, stb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  dfr_window #(.FW(FW)) u_win (
    .clk(clk), .rst_n(rst_i_n), .shift_en(ser_vld), .bit_in(ser_bit), .win_nxt(win_nxt)
  );

  dfr_check #(.PW(PW)) u_chk (
    .win(win_nxt), .clk_ok(clk_ok), .par_ok(par_ok), .word(dec_word)
  );

  dfr_lock #(.FW(FW), .ACQ(ACQ)) u_lock (
    .clk(clk), .rst_n(rst_i_n), .bit_vld(ser_vld), .clk_ok(clk_ok), .par_ok(par_ok),
    .deliver(deliver), .lock_q(lock_q), .lock_n(lock_n)
  );

  always_comb begin
    stb_n  = deliver;
    word_n = word_q;
    if (deliver)     word_n = dec_word;
    else if (!lock_n) word_n = '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      word_q <= word_n;
      stb_q  <= stb_n;
    end
  end

  assign par_oe   = rx_en;
  assign par_word = rx_en ? word_q : '0;
  assign word_stb = rx_en & stb_q;
  assign locked   = lock_q;

  assert_quiet_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !lock_q |-> (word_q == '0 && !stb_q));

  assert_lock_with_word_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(lock_q) |-> stb_q);

  assert_stb_from_bit_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    stb_q |-> $past(ser_vld));
endmodule

// File: tb/sim_dfr_deframer.sv
module sim_dfr_deframer;
  logic        clk = 1'b0;
  logic        rst_n, ser_bit, ser_vld, rx_en;
  logic [23:0] par_word;
  logic        word_stb, par_oe, locked;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  dfr_deframer u0 (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_vld(ser_vld), .rx_en(rx_en),
    .par_word(par_word), .word_stb(word_stb), .par_oe(par_oe), .locked(locked)
  );

  // Row: {data[23:0], balance flag, break end clock bit, bad parity, expected lock}
  localparam logic [27:0] VEC [7] = '{
    {24'hA5A5A5, 1'b0, 1'b0, 1'b0, 1'b0},
    {24'h123456, 1'b1, 1'b0, 1'b0, 1'b0},
    {24'h000000, 1'b1, 1'b0, 1'b0, 1'b0},
    {24'h0F0F0F, 1'b0, 1'b0, 1'b0, 1'b1},
    {24'h800001, 1'b1, 1'b0, 1'b0, 1'b1},
    {24'h5A5A5A, 1'b0, 1'b0, 1'b1, 1'b1},
    {24'h777777, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_bit = b;
    ser_vld = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [23:0] d, input logic dcb, input logic brk, input logic bad);
    logic [23:0] pay;
    logic        dca;
    pay = dcb ? ~d : d;
    dca = (^pay) ^ dcb ^ bad;
    send_bit(1'b1);
    send_bit(dcb);
    send_bit(dca);
    for (int i = 0; i < 24; i++) send_bit(pay[i]);
    send_bit(brk);
    ser_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    ser_vld = 1'b0;
    ser_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk(!locked && !word_stb && par_word == 24'h0, "R1 reset state",
        {7'h0, locked, word_stb, par_word}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rx_en = 1'b1;
    @(negedge clk);
    do_reset();

    // Table: aligned start, R2/R3/R8 acquire and decode, R6 parity ignored, R7 drop
    for (int i = 0; i < 7; i++) begin
      logic [23:0] d;
      logic        exp_l;
      d     = VEC[i][27:4];
      exp_l = VEC[i][0];
      send_frame(d, VEC[i][3], VEC[i][2], VEC[i][1]);
      chk(locked == exp_l, "R3/R7 lock after frame", {31'h0, locked}, {31'h0, exp_l});
      chk(word_stb == exp_l, "R3/R7 strobe with word", {31'h0, word_stb}, {31'h0, exp_l});
      chk(par_word == (exp_l ? d : 24'h0), "R2/R8/R6/R9 word value",
          {8'h0, par_word}, {8'h0, (exp_l ? d : 24'h0)});
    end

    // R11: automatic relock on continuing traffic
    for (int f = 0; f < 8; f++) send_frame(24'h000000, 1'b0, 1'b0, 1'b0);
    chk(locked, "R11 relock after loss", {31'h0, locked}, 32'h1);
    send_frame(24'hABCDEF, 1'b1, 1'b0, 1'b0);
    chk(par_word == 24'hABCDEF && word_stb, "R11 R8 word after relock",
        {7'h0, word_stb, par_word}, {8'h1, 24'hABCDEF});

    // R10: receive enable low gates outputs, lock unaffected
    rx_en = 1'b0;
    send_frame(24'h135790, 1'b0, 1'b0, 1'b0);
    chk(par_word == 24'h0 && !word_stb && !par_oe, "R10 outputs off when disabled",
        {6'h0, par_oe, word_stb, par_word}, 32'h0);
    chk(locked, "R10 lock unaffected by enable", {31'h0, locked}, 32'h1);
    rx_en = 1'b1;
    send_frame(24'h2468AC, 1'b0, 1'b0, 1'b0);
    chk(par_word == 24'h2468AC && word_stb && par_oe, "R10 outputs back when enabled",
        {6'h0, par_oe, word_stb, par_word}, {8'h3, 24'h2468AC});

    // R1: reset in the middle of lock
    do_reset();
    chk(!locked && par_word == 24'h0, "R1 state after mid-lock reset",
        {7'h0, locked, word_stb, par_word}, 32'h0);

    // R5: parity failure during search restarts the count
    for (int f = 0; f < 3; f++) send_frame(24'h000000, 1'b0, 1'b0, 1'b0);
    send_frame(24'h000000, 1'b0, 1'b0, 1'b1);
    chk(!locked, "R5 no lock with bad parity 4th frame", {31'h0, locked}, 32'h0);
    for (int f = 0; f < 3; f++) send_frame(24'h000000, 1'b0, 1'b0, 1'b0);
    chk(!locked, "R5 count restarted after parity fail", {31'h0, locked}, 32'h0);
    send_frame(24'h000000, 1'b0, 1'b0, 1'b0);
    chk(locked && word_stb, "R5 R3 lock on 4th clean frame after fail",
        {30'h0, locked, word_stb}, 32'h3);

    // R4: misaligned start, search slips to the frame boundary
    do_reset();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    ser_vld = 1'b0;
    for (int f = 0; f < 3; f++) send_frame(24'h000000, 1'b0, 1'b0, 1'b0);
    chk(!locked, "R4 no lock before four aligned frames", {31'h0, locked}, 32'h0);
    for (int f = 0; f < 5; f++) send_frame(24'h000000, 1'b0, 1'b0, 1'b0);
    chk(locked, "R4 lock found from misaligned start", {31'h0, locked}, 32'h1);
    send_frame(24'hC3C3C3, 1'b0, 1'b0, 1'b0);
    chk(par_word == 24'hC3C3C3, "R4 R2 aligned word", {8'h0, par_word}, {8'h0, 24'hC3C3C3});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule